// File: doc/BRIEF.md
# Suspend Modulation Throttle Controller

This block slows a processor by pulling its active-low suspend input low for part of every period. The time spent suspended and the time spent running are each programmed as a count of fixed ticks. A tick is a single-cycle pulse that a prescaler derives from the system clock, 32 microseconds in normal use. With a suspended count S and a running count R, the core works about R/(R+S) of the time. Software sets the counts, the enables and two speedup hold times through a byte-wide register port.

Two activity inputs, one for interrupts and one for video accesses, can lift throttling for a while. Each has its own enable bit and its own hold register, counted in units of roughly one millisecond. A new event reloads the hold timer to its full value. While either timer is nonzero the suspend pin stays released. When both reach zero the modulation pattern shows again. The phase sequencer keeps running under a speedup, so the pattern continues from wherever it has reached.

Top module: `susmod_throttle`

## Requirements
- R1: After reset every register reads 0, `susp_n` is high and the sequencer waits in the running (released) phase.
- R2: Phases advance only on the tick pulse, which comes once every `CLK_PER_TICK` clocks. A millisecond unit is `MS_TICKS` ticks.
- R3: With modulation enabled and both counts nonzero, `susp_n` is low for ON-count ticks and then high for OFF-count ticks, over and over. The ON count is at address 0x95 and the OFF count at 0x94.
- R4: Bit 0 of the control register at 0x96 enables modulation. While it is 0, `susp_n` stays high and the sequencer returns to the running phase with no time left.
- R5: An ON count of 0 keeps `susp_n` high at every phase boundary.
- R6: An OFF count of 0 with a nonzero ON count keeps `susp_n` low for as long as modulation is enabled.
- R7: A write to either count is sampled only at the next phase boundary. A phase already in progress runs for its full latched length.
- R8: When bit 3 of 0x80 is set, an `irq_evt` pulse loads the interrupt hold timer from 0x8C. The timer counts down once per millisecond unit, and while it is nonzero `susp_n` is high. A further event reloads it.
- R9: When bit 4 of 0x80 is set, a `vid_evt` pulse does the same with the video hold timer, which loads from 0x8D.
- R10: The registers at 0x80, 0x81, 0x82, 0x8C, 0x8D, 0x94, 0x95 and 0x96 read back the last byte written to them. Any other address reads 0 and ignores writes.
- R11: An activity event whose enable bit is clear has no effect on `susp_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for writes and reads |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video access pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
A wrong remaining-time count or a phase register that flips at the wrong moment moves an edge of `susp_n`. The per-clock comparison against the bench model catches this within one tick of the fault. A latched phase length that follows a register write too early changes the first edge after that write, not later ones, so the bench writes the counts in the middle of a phase. A speedup timer that reloads or expires wrongly shows up as `susp_n` rising or falling one millisecond unit off. The scenarios are arranged so that such an edge lands inside a window where the expected level is fixed.

// File: rtl/susmod_pkg.sv
package susmod_pkg;

  localparam logic [7:0] A_PMEN0    = 8'h80;
  localparam logic [7:0] A_PMEN1    = 8'h81;
  localparam logic [7:0] A_PMEN2    = 8'h82;
  localparam logic [7:0] A_IRQ_HOLD = 8'h8C;
  localparam logic [7:0] A_VID_HOLD = 8'h8D;
  localparam logic [7:0] A_RUN_LEN  = 8'h94;
  localparam logic [7:0] A_HALT_LEN = 8'h95;
  localparam logic [7:0] A_MOD_CTL  = 8'h96;

  localparam int B_GLOBAL  = 0;
  localparam int B_IDLE    = 1;
  localparam int B_IRQ_SPD = 3;
  localparam int B_VID_SPD = 4;
  localparam int B_MOD_EN  = 0;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HALT = 1'b1
  } phase_e;

  typedef struct packed {
    logic [7:0] pmen0;
    logic [7:0] pmen1;
    logic [7:0] pmen2;
    logic [7:0] irq_hold;
    logic [7:0] vid_hold;
    logic [7:0] run_len;
    logic [7:0] halt_len;
    logic [7:0] mod_ctl;
  } cfg_t;

  function automatic logic [7:0] dec_floor(input logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

  function automatic logic last_tick(input logic [7:0] remaining);
    return remaining <= 8'd1;
  endfunction

endpackage

// File: rtl/susmod_prescale.sv
module susmod_prescale #(
  parameter int CLK_PER_TICK = 3200,
  parameter int MS_TICKS     = 31
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic ms_pulse
);
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(CLK_PER_TICK - 1);
  localparam logic [MW-1:0] M_LAST = MW'(MS_TICKS - 1);

  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] ms_cnt;

  assign tick     = (pre_cnt == P_LAST);
  assign ms_pulse = tick && (ms_cnt == M_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) ms_cnt <= (ms_cnt == M_LAST) ? '0 : ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/susmod_regs.sv
module susmod_regs
  import susmod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output cfg_t       cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        A_PMEN0:    cfg.pmen0    <= wdata;
        A_PMEN1:    cfg.pmen1    <= wdata;
        A_PMEN2:    cfg.pmen2    <= wdata;
        A_IRQ_HOLD: cfg.irq_hold <= wdata;
        A_VID_HOLD: cfg.vid_hold <= wdata;
        A_RUN_LEN:  cfg.run_len  <= wdata;
        A_HALT_LEN: cfg.halt_len <= wdata;
        A_MOD_CTL:  cfg.mod_ctl  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_PMEN0:    rdata = cfg.pmen0;
      A_PMEN1:    rdata = cfg.pmen1;
      A_PMEN2:    rdata = cfg.pmen2;
      A_IRQ_HOLD: rdata = cfg.irq_hold;
      A_VID_HOLD: rdata = cfg.vid_hold;
      A_RUN_LEN:  rdata = cfg.run_len;
      A_HALT_LEN: rdata = cfg.halt_len;
      A_MOD_CTL:  rdata = cfg.mod_ctl;
      default:    rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/susmod_speedup.sv
module susmod_speedup
  import susmod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       arm,
  input  logic [7:0] reload,
  input  logic       ms_pulse,
  output logic       active,
  output logic [7:0] tmr
);
  assign active = (tmr != 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr <= 8'd0;
    else if (evt && arm)    tmr <= reload;
    else if (ms_pulse)      tmr <= dec_floor(tmr);
  end
endmodule

// File: rtl/susmod_seq.sv
module susmod_seq
  import susmod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_en,
  input  logic       tick,
  input  logic [7:0] halt_len,
  input  logic [7:0] run_len,
  output phase_e     phase,
  output logic       boundary,
  output logic [7:0] remaining
);
  phase_e     nxt_phase;
  logic [7:0] nxt_len;

  assign boundary = mod_en && tick && last_tick(remaining);

  always_comb begin
    if (halt_len == 8'd0) begin
      nxt_phase = PH_RUN;
      nxt_len   = run_len;
    end else if (run_len == 8'd0) begin
      nxt_phase = PH_HALT;
      nxt_len   = halt_len;
    end else if (phase == PH_RUN) begin
      nxt_phase = PH_HALT;
      nxt_len   = halt_len;
    end else begin
      nxt_phase = PH_RUN;
      nxt_len   = run_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RUN;
      remaining <= 8'd0;
    end else if (!mod_en) begin
      phase     <= PH_RUN;
      remaining <= 8'd0;
    end else if (boundary) begin
      phase     <= nxt_phase;
      remaining <= nxt_len;
    end else if (tick) begin
      remaining <= remaining - 8'd1;
    end
  end
endmodule

// File: rtl/susmod_throttle.sv
module susmod_throttle
  import susmod_pkg::*;
#(
  parameter int CLK_PER_TICK = 3200,
  parameter int MS_TICKS     = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       irq_evt,
  input  logic       vid_evt,
  output logic       susp_n
);
  cfg_t       cfg;
  logic       tick;
  logic       ms_pulse;
  logic       mod_en;
  logic       irq_arm;
  logic       vid_arm;
  logic       irq_active;
  logic       vid_active;
  logic [7:0] irq_tmr;
  logic [7:0] vid_tmr;
  logic       override;
  phase_e     phase;
  logic       phase_halt;
  logic       boundary;
  logic [7:0] remaining;

  susmod_prescale #(.CLK_PER_TICK(CLK_PER_TICK), .MS_TICKS(MS_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ms_pulse(ms_pulse)
  );

  susmod_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  assign mod_en  = cfg.mod_ctl[B_MOD_EN];
  assign irq_arm = cfg.pmen0[B_IRQ_SPD];
  assign vid_arm = cfg.pmen0[B_VID_SPD];

  susmod_speedup u_irq (
    .clk(clk), .rst_n(rst_n), .evt(irq_evt), .arm(irq_arm),
    .reload(cfg.irq_hold), .ms_pulse(ms_pulse),
    .active(irq_active), .tmr(irq_tmr)
  );

  susmod_speedup u_vid (
    .clk(clk), .rst_n(rst_n), .evt(vid_evt), .arm(vid_arm),
    .reload(cfg.vid_hold), .ms_pulse(ms_pulse),
    .active(vid_active), .tmr(vid_tmr)
  );

  assign override = irq_active | vid_active;

  susmod_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tick(tick),
    .halt_len(cfg.halt_len), .run_len(cfg.run_len),
    .phase(phase), .boundary(boundary), .remaining(remaining)
  );

  assign phase_halt = (phase == PH_HALT);
  assign susp_n     = ~(mod_en & phase_halt & ~override);
endmodule

// File: rtl/susmod_throttle_chk.sv
module susmod_throttle_chk #(
  parameter int CLK_PER_TICK = 3200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       mod_en,
  input logic       override,
  input logic       phase_halt,
  input logic       boundary,
  input logic [7:0] halt_len,
  input logic       susp_n,
  input logic       irq_evt,
  input logic       irq_arm,
  input logic [7:0] irq_reload,
  input logic [7:0] irq_tmr
);
  a_r4_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> susp_n);

  a_r8_speedup_releases: assert property (@(posedge clk) disable iff (!rst_n)
    override |-> susp_n);

  a_r8_event_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && irq_arm) |=> (irq_tmr == $past(irq_reload)));

  a_r2_phase_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tick) |=> $stable(phase_halt));

  a_r5_zero_on_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && halt_len == 8'd0) |=> !phase_halt);

  generate
    if (CLK_PER_TICK > 1) begin : g_tick
      a_r2_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind susmod_throttle susmod_throttle_chk #(.CLK_PER_TICK(CLK_PER_TICK)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mod_en(mod_en),
  .override(override), .phase_halt(phase_halt), .boundary(boundary),
  .halt_len(cfg.halt_len), .susp_n(susp_n), .irq_evt(irq_evt),
  .irq_arm(irq_arm), .irq_reload(cfg.irq_hold), .irq_tmr(irq_tmr)
);

// File: tb/susmod_throttle_bench.sv
`timescale 1ns/1ps
module susmod_throttle_bench;
  localparam int P = 4;
  localparam int M = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       irq_evt = 1'b0;
  logic       vid_evt = 1'b0;
  logic       susp_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  susmod_throttle #(.CLK_PER_TICK(P), .MS_TICKS(M)) u_susmod_throttle (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_evt(irq_evt),
    .vid_evt(vid_evt), .susp_n(susp_n)
  );

  // Behavioural reference: integer counters and a register array
  int  m_clk_in_tick, m_tick_in_ms, m_irq, m_vid, m_left;
  bit  m_suspended;
  byte unsigned m_reg [int];
  bit  m_susp_n;

  function automatic byte unsigned rd_model(input int a);
    if (m_reg.exists(a)) return m_reg[a];
    return 0;
  endfunction

  function automatic bit mapped(input int a);
    return a == 'h80 || a == 'h81 || a == 'h82 || a == 'h8C || a == 'h8D ||
           a == 'h94 || a == 'h95 || a == 'h96;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk_in_tick = 0; m_tick_in_ms = 0; m_irq = 0; m_vid = 0;
      m_left = 0; m_suspended = 0;
      m_reg.delete();
    end else begin
      bit t, ms;
      int on_c, off_c;
      t  = (m_clk_in_tick == P - 1);
      ms = t && (m_tick_in_ms == M - 1);
      m_clk_in_tick = t ? 0 : m_clk_in_tick + 1;
      if (t) m_tick_in_ms = (m_tick_in_ms + 1) % M;
      if (irq_evt && rd_model('h80)[3]) m_irq = rd_model('h8C);
      else if (ms && m_irq > 0) m_irq = m_irq - 1;
      if (vid_evt && rd_model('h80)[4]) m_vid = rd_model('h8D);
      else if (ms && m_vid > 0) m_vid = m_vid - 1;
      on_c  = rd_model('h95);
      off_c = rd_model('h94);
      if (!rd_model('h96)[0]) begin
        m_suspended = 0; m_left = 0;
      end else if (t) begin
        if (m_left > 1) m_left = m_left - 1;
        else if (on_c == 0) begin m_suspended = 0; m_left = off_c; end
        else if (off_c == 0) begin m_suspended = 1; m_left = on_c; end
        else begin
          m_suspended = !m_suspended;
          m_left = m_suspended ? on_c : off_c;
        end
      end
      if (cfg_we && mapped(cfg_addr)) m_reg[cfg_addr] = cfg_wdata;
    end
    m_susp_n = !(rd_model('h96)[0] && m_suspended && m_irq == 0 && m_vid == 0);
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (susp_n !== m_susp_n) begin
        errors++;
        $display("FAIL R3 per-cycle susp_n at %0t: actual %0b expected %0b",
                 $time, susp_n, m_susp_n);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic pulse(input bit is_irq);
    @(negedge clk);
    if (is_irq) irq_evt = 1'b1; else vid_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0; vid_evt = 1'b0;
  endtask

  // counts low samples over n negedges
  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!susp_n) lows++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(susp_n == 1'b1, "R1 susp_n after reset", susp_n, 1);
    rd_chk(8'h96, 0, "R1 ctl reset");
    rd_chk(8'h95, 0, "R1 on count reset");
    rd_chk(8'h8C, 0, "R1 irq hold reset");
    // R10: readback and unmapped address
    wr(8'h81, 8'h5A);
    rd_chk(8'h81, 8'h5A, "R10 readback 0x81");
    wr(8'h90, 8'hFF);
    rd_chk(8'h90, 0, "R10 unmapped reads zero");
    rd_chk(8'h82, 0, "R10 unmapped write ignored");
    // R3: ON=2 ticks, OFF=3 ticks
    wr(8'h95, 8'd2);
    wr(8'h94, 8'd3);
    wr(8'h96, 8'h01);
    @(negedge clk);
    while (susp_n) @(negedge clk);
    count_low(20 * P / 4 * 10, lows);
    chk(lows == 2 * P * 10, "R3 duty over ten periods", lows, 2 * P * 10);
    // R2: low run length equals ON ticks times clocks per tick
    while (susp_n) @(negedge clk);
    lows = 0;
    while (!susp_n) begin lows++; @(negedge clk); end
    chk(lows == 2 * P, "R2 low run length", lows, 2 * P);
    // R7: mid-phase rewrites, model compares each cycle
    repeat (P + 1) @(negedge clk);
    wr(8'h95, 8'd5);
    wr(8'h94, 8'd1);
    repeat (60) @(negedge clk);
    // R5: ON count zero
    wr(8'h95, 8'd0);
    repeat (10 * P) @(negedge clk);
    count_low(100, lows);
    chk(lows == 0, "R5 on zero never asserts", lows, 0);
    // R6: OFF count zero
    wr(8'h95, 8'd3);
    wr(8'h94, 8'd0);
    repeat (10 * P) @(negedge clk);
    count_low(100, lows);
    chk(lows == 100, "R6 off zero stays asserted", lows, 100);
    // R11: disarmed events ignored
    wr(8'h8C, 8'd2);
    wr(8'h8D, 8'd5);
    pulse(1);
    chk(susp_n == 1'b0, "R11 irq disarmed", susp_n, 0);
    pulse(0);
    chk(susp_n == 1'b0, "R11 vid disarmed", susp_n, 0);
    // R8: interrupt speedup and retrigger
    wr(8'h80, 8'h08);
    pulse(1);
    chk(susp_n == 1'b1, "R8 irq speedup releases", susp_n, 1);
    repeat (P * M) @(negedge clk);
    pulse(1);
    count_low(P * M, lows);
    chk(lows == 0, "R8 retrigger holds release", lows, 0);
    repeat (3 * P * M) @(negedge clk);
    chk(susp_n == 1'b0, "R8 throttle resumes", susp_n, 0);
    // R9: video speedup
    wr(8'h80, 8'h10);
    pulse(0);
    count_low(4 * P * M, lows);
    chk(lows == 0, "R9 vid speedup holds release", lows, 0);
    repeat (3 * P * M) @(negedge clk);
    chk(susp_n == 1'b0, "R9 throttle resumes", susp_n, 0);
    // R4: disable modulation
    wr(8'h96, 8'h00);
    count_low(50, lows);
    chk(lows == 0, "R4 disabled stays high", lows, 0);
    rd_chk(8'h80, 8'h10, "R10 readback 0x80");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule